// File: doc/BRIEF.md
# Comma-Aligned Word Deserializer with Line Activity Monitor

This block sits behind a clock-recovery front end. It receives one serial bit on every edge of the recovered bit clock. It collects the bits into 10-bit words and raises a one-clock word strobe each time a word is complete. The bit received first in each word lands in the most significant bit of the output.

The block searches the incoming stream for the seven-bit comma prefix 0011111, written in order of arrival. Detection is armed only while the comma-detect enable is high and the active-low lock-to-reference control is high (idle). When a comma is detected, the word boundary moves so that the comma opens a new word. A flag then pulses together with the strobe of that word.

A separate monitor watches for transitions on the serial line. It raises loss of signal once four word periods (40 bit clocks) pass without a transition. It drops the flag again on the next transition.

Top module: `serial_word_aligner`

## Requirements
- R1: While the synchronous reset `rst` is high, at the following clock edge `word_o` becomes 0, `word_vld_o` becomes 0, `comma_o` becomes 0 and `los_o` becomes 1; the bit counter and the shift window are cleared to zero.
- R2: Each output word holds the last 10 sampled bits, with the earliest in `word_o[9]` and the latest in `word_o[0]`; `word_o` and `word_vld_o` update on the same edge that samples the tenth bit of the word.
- R3: Without realignment, `word_vld_o` is high for exactly one clock in every 10. The first strobe comes on the tenth sampling edge after reset is released.
- R4: With `comma_en_i`=1 and `lock_ref_n_i`=1, seven consecutive bits 0,0,1,1,1,1,1 (earliest first) form a detected comma. The next strobe then falls on the edge that samples the third bit after the comma, and that word has `word_o[9:3]`=7'b0011111. If the comma is misaligned, the partial word in progress is discarded without a strobe.
- R5: `comma_o` is high for exactly the one clock in which the strobe of the word opened by a detected comma is high, and is low at all other times.
- R6: A comma whose first bit is already the first bit of a word sets `comma_o` on that word, and the 10-clock strobe spacing stays as it was.
- R7: With `comma_en_i`=0, a comma pattern causes no realignment and `comma_o` stays 0.
- R8: With `lock_ref_n_i`=0, a comma pattern causes no realignment and `comma_o` stays 0, even when `comma_en_i`=1.
- R9: The inverted prefix 1,1,0,0,0,0,0 is not a comma: it causes no realignment and no flag.
- R10: `los_o` rises on the 40th consecutive sampling edge with no change of the serial bit, and stays low on the 39 edges before it.
- R11: `los_o` falls on the edge that samples a bit that differs from the previous sampled bit. Each such change restarts the 40-clock count.
- R12: After reset, `los_o` stays high until the first sampled bit that differs from the previous one. The previous bit is taken as 0 at reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered bit clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_i | input | 1 | Serial data bit |
| comma_en_i | input | 1 | Arms comma detection and realignment when high |
| lock_ref_n_i | input | 1 | Lock-to-reference control, active low; low disables comma detection |
| word_o | output | 10 | Parallel word, first received bit in bit 9 |
| word_vld_o | output | 1 | One-clock strobe marking a new word |
| comma_o | output | 1 | Pulses with the word that begins with a detected comma |
| los_o | output | 1 | Loss of signal: no line transition within 40 bit clocks |

## Verification
A wrong bit count shows up within one word period as a strobe on the wrong edge. The scoreboard catches this immediately as a missing or unexpected word. A bad window or a bad comma match produces a wrong word value or a misplaced flag, at the first strobe after the offending bits. This happens no more than ten clocks after the comma. A wrong idle counter moves the loss-of-signal edge away from the 40th quiet clock, and the probes placed just before and just on that edge detect it.

// File: rtl/serdes_align_pkg.sv
package serdes_align_pkg;
    localparam int unsigned DEF_WORD_W    = 10;
    localparam int unsigned DEF_COMMA_LEN = 7;
    localparam logic [DEF_COMMA_LEN-1:0] DEF_COMMA_PAT = 7'b0011111;
    localparam int unsigned DEF_LOS_WORDS = 4;

    function automatic int unsigned cnt_width(input int unsigned maxval);
        return (maxval < 2) ? 1 : $clog2(maxval + 1);
    endfunction
endpackage

// File: rtl/sa_shift_window.sv
module sa_shift_window
    import serdes_align_pkg::*;
#(
    parameter int unsigned WORD_W    = DEF_WORD_W,
    parameter int unsigned COMMA_LEN = DEF_COMMA_LEN,
    parameter logic [COMMA_LEN-1:0] COMMA_PAT = DEF_COMMA_PAT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_i,
    input  logic              arm_i,
    output logic [WORD_W-1:0] win_nxt_o,
    output logic              det_o
);
    typedef struct packed {
        logic [WORD_W-1:0] win;
    } win_state_t;

    win_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.win = {st_q.win[WORD_W-2:0], ser_i};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign win_nxt_o = st_d.win;
    assign det_o     = arm_i && (st_d.win[COMMA_LEN-1:0] == COMMA_PAT);
endmodule

// File: rtl/sa_word_framer.sv
module sa_word_framer
    import serdes_align_pkg::*;
#(
    parameter int unsigned WORD_W    = DEF_WORD_W,
    parameter int unsigned COMMA_LEN = DEF_COMMA_LEN,
    parameter logic [COMMA_LEN-1:0] COMMA_PAT = DEF_COMMA_PAT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] win_nxt_i,
    input  logic              det_i,
    output logic [WORD_W-1:0] word_o,
    output logic              vld_o,
    output logic              comma_o
);
    localparam int unsigned CNT_W = cnt_width(WORD_W);
    localparam logic [CNT_W-1:0] CNT_FULL  = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] CNT_COMMA = CNT_W'(COMMA_LEN);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic              pend;
        logic [WORD_W-1:0] word;
        logic              vld;
        logic              comma;
    } frm_state_t;

    frm_state_t st_d, st_q;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        st_d       = st_q;
        st_d.vld   = 1'b0;
        st_d.comma = 1'b0;
        cnt_inc    = st_q.cnt + 1'b1;
        if (det_i) begin
            st_d.cnt  = CNT_COMMA;
            st_d.pend = 1'b1;
        end else if (cnt_inc == CNT_FULL) begin
            st_d.cnt   = '0;
            st_d.vld   = 1'b1;
            st_d.word  = win_nxt_i;
            st_d.comma = st_q.pend;
            st_d.pend  = 1'b0;
        end else begin
            st_d.cnt = cnt_inc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_o  = st_q.word;
    assign vld_o   = st_q.vld;
    assign comma_o = st_q.comma;

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt < CNT_FULL); // R3
    AST_STROBE_GAP: assert property (@(posedge clk) disable iff (rst)
        st_q.vld |=> !st_q.vld); // R3
    AST_COMMA_WORD: assert property (@(posedge clk) disable iff (rst)
        st_q.comma |-> (st_q.vld && st_q.word[WORD_W-1 -: COMMA_LEN] == COMMA_PAT)); // R5
    AST_PEND_SOURCE: assert property (@(posedge clk) disable iff (rst)
        (!det_i && !st_q.pend) |=> !st_q.pend); // R4
endmodule

// File: rtl/sa_activity_monitor.sv
module sa_activity_monitor
    import serdes_align_pkg::*;
#(
    parameter int unsigned WORD_W    = DEF_WORD_W,
    parameter int unsigned LOS_WORDS = DEF_LOS_WORDS
) (
    input  logic clk,
    input  logic rst,
    input  logic ser_i,
    output logic los_o
);
    localparam int unsigned LOS_LIMIT = WORD_W * LOS_WORDS;
    localparam int unsigned IDLE_W    = cnt_width(LOS_LIMIT);
    localparam logic [IDLE_W-1:0] IDLE_LAST = IDLE_W'(LOS_LIMIT - 1);

    typedef struct packed {
        logic              prev;
        logic [IDLE_W-1:0] idle;
        logic              los;
    } mon_state_t;

    mon_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = ser_i;
        if (ser_i != st_q.prev) begin
            st_d.idle = '0;
            st_d.los  = 1'b0;
        end else if (st_q.idle == IDLE_LAST) begin
            st_d.los = 1'b1;
        end else begin
            st_d.idle = st_q.idle + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= '0;
            st_q.los  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign los_o = st_q.los;

    AST_LOS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (ser_i != st_q.prev) |=> !los_o); // R11
    AST_LOS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (los_o && ser_i == st_q.prev) |=> los_o); // R10
endmodule

// File: rtl/serial_word_aligner.sv
module serial_word_aligner
    import serdes_align_pkg::*;
#(
    parameter int unsigned WORD_W    = DEF_WORD_W,
    parameter int unsigned COMMA_LEN = DEF_COMMA_LEN,
    parameter logic [COMMA_LEN-1:0] COMMA_PAT = DEF_COMMA_PAT,
    parameter int unsigned LOS_WORDS = DEF_LOS_WORDS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_i,
    input  logic              comma_en_i,
    input  logic              lock_ref_n_i,
    output logic [WORD_W-1:0] word_o,
    output logic              word_vld_o,
    output logic              comma_o,
    output logic              los_o
);
    logic [WORD_W-1:0] win_nxt;
    logic              det;
    logic              arm;

    assign arm = comma_en_i & lock_ref_n_i;

    sa_shift_window #(
        .WORD_W(WORD_W), .COMMA_LEN(COMMA_LEN), .COMMA_PAT(COMMA_PAT)
    ) u_win (
        .clk(clk), .rst(rst), .ser_i(ser_i), .arm_i(arm),
        .win_nxt_o(win_nxt), .det_o(det)
    );

    sa_word_framer #(
        .WORD_W(WORD_W), .COMMA_LEN(COMMA_LEN), .COMMA_PAT(COMMA_PAT)
    ) u_frm (
        .clk(clk), .rst(rst), .win_nxt_i(win_nxt), .det_i(det),
        .word_o(word_o), .vld_o(word_vld_o), .comma_o(comma_o)
    );

    sa_activity_monitor #(
        .WORD_W(WORD_W), .LOS_WORDS(LOS_WORDS)
    ) u_mon (
        .clk(clk), .rst(rst), .ser_i(ser_i), .los_o(los_o)
    );

    AST_EN_NO_DET: assert property (@(posedge clk) disable iff (rst)
        !comma_en_i |-> !det); // R7
    AST_LOCK_NO_DET: assert property (@(posedge clk) disable iff (rst)
        !lock_ref_n_i |-> !det); // R8
endmodule

// File: tb/serial_word_aligner_tb.sv
module serial_word_aligner_tb;
    localparam int W = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ser_i = 1'b0;
    logic         comma_en_i = 1'b0;
    logic         lock_ref_n_i = 1'b1;
    logic [W-1:0] word_o;
    logic         word_vld_o;
    logic         comma_o;
    logic         los_o;

    always #4 clk = ~clk;

    serial_word_aligner u_dut (
        .clk(clk), .rst(rst), .ser_i(ser_i), .comma_en_i(comma_en_i),
        .lock_ref_n_i(lock_ref_n_i), .word_o(word_o), .word_vld_o(word_vld_o),
        .comma_o(comma_o), .los_o(los_o)
    );

    typedef struct {
        logic [W-1:0] word;
        logic         comma;
        string        tag;
    } exp_t;

    exp_t  sb_q[$];
    int    checks = 0;
    int    failures = 0;
    string cur_tag = "R2";

    int           m_cnt;
    logic [6:0]   m_hist;
    logic         m_pend;
    logic [W-1:0] m_word;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        ser_i = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        sb_q.delete();
        m_cnt = 0; m_hist = '0; m_pend = 1'b0; m_word = '0;
    endtask

    task automatic send_bit(input logic b);
        exp_t e;
        bit   det;
        int   n;
        @(negedge clk);
        rst = 1'b0;
        ser_i = b;
        m_hist = {m_hist[5:0], b};
        m_word = {m_word[W-2:0], b};
        n = m_cnt + 1;
        det = comma_en_i && lock_ref_n_i && (m_hist == 7'b0011111);
        if (det) begin
            m_cnt = 7;
            m_pend = 1'b1;
        end else if (n == W) begin
            e.word = m_word; e.comma = m_pend; e.tag = cur_tag;
            sb_q.push_back(e);
            m_pend = 1'b0;
            m_cnt = 0;
        end else begin
            m_cnt = n;
        end
        @(posedge clk);
        #1;
    endtask

    task automatic send_bits(input logic [15:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
    endtask

    // monitor / scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (!rst) begin
                if (comma_o && !word_vld_o)
                    check(0, cur_tag, "comma without strobe", 1, 0);
                if (word_vld_o) begin
                    if (sb_q.size() == 0) begin
                        check(0, cur_tag, "unexpected strobe", int'(word_o), 0);
                    end else begin
                        exp_t e;
                        e = sb_q.pop_front();
                        check(word_o == e.word, e.tag, "word", int'(word_o), int'(e.word));
                        check(comma_o == e.comma, e.tag, "comma flag", int'(comma_o), int'(e.comma));
                    end
                end else if (sb_q.size() != 0) begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(0, e.tag, "missing strobe", 0, int'(e.word));
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // reset state
        do_reset();
        check(word_o == '0, "R1", "word after reset", int'(word_o), 0);
        check(word_vld_o == 1'b0, "R1", "strobe after reset", int'(word_vld_o), 0);
        check(comma_o == 1'b0, "R1", "comma after reset", int'(comma_o), 0);
        check(los_o == 1'b1, "R12", "los after reset", int'(los_o), 1);

        // plain framing, detection disabled
        comma_en_i = 1'b0;
        cur_tag = "R3";
        send_bit(1'b0);
        check(los_o == 1'b1, "R12", "los with no transition", int'(los_o), 1);
        cur_tag = "R2";
        send_bits(16'b101011001, 9);
        send_bits(16'b0111000101, 10);
        cur_tag = "R7";
        send_bits(16'b1100111110, 10);
        send_bits(16'b0110011111, 10);

        // misaligned comma with detection armed
        comma_en_i = 1'b1;
        cur_tag = "R4";
        send_bits(16'b1010, 4);
        send_bits(16'b0011111010, 10);
        cur_tag = "R5";
        send_bits(16'b1010101010, 10);
        // aligned comma
        cur_tag = "R6";
        send_bits(16'b0011111001, 10);
        send_bits(16'b1001100110, 10);

        // lock-to-reference active: no detection
        lock_ref_n_i = 1'b0;
        cur_tag = "R8";
        send_bits(16'b101, 3);
        send_bits(16'b0011111010, 10);
        send_bits(16'b0101010, 7);
        lock_ref_n_i = 1'b1;

        // inverted prefix is not a comma
        cur_tag = "R9";
        send_bits(16'b10, 2);
        send_bits(16'b1100000101, 10);
        send_bits(16'b01010101, 8);

        // loss of signal timing
        comma_en_i = 1'b0;
        do_reset();
        cur_tag = "R10";
        send_bit(1'b1);
        check(los_o == 1'b0, "R11", "los after first transition", int'(los_o), 0);
        for (int i = 0; i < 39; i++) send_bit(1'b1);
        check(los_o == 1'b0, "R10", "los after 39 quiet clocks", int'(los_o), 0);
        send_bit(1'b1);
        check(los_o == 1'b1, "R10", "los after 40 quiet clocks", int'(los_o), 1);
        send_bit(1'b0);
        check(los_o == 1'b0, "R11", "los after transition", int'(los_o), 0);
        for (int i = 0; i < 20; i++) send_bit(1'b0);
        send_bit(1'b1);
        for (int i = 0; i < 39; i++) send_bit(1'b1);
        check(los_o == 1'b0, "R11", "count restarted at transition", int'(los_o), 0);
        send_bit(1'b1);
        check(los_o == 1'b1, "R10", "los after restart window", int'(los_o), 1);

        @(posedge clk);
        #3;
        check(sb_q.size() == 0, "R3", "leftover expected words", sb_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule